// File: doc/BRIEF.md
# I/Q Automatic Gain Control Loop

This block levels a complex baseband stream. Each accepted I/Q pair is multiplied by a floating-point gain word, made of a 4-bit power-of-two exponent and an 8-bit mantissa, and saturated to the output width. The scaled pair also feeds an iterative vectoring magnitude estimator. A loop filter compares that estimate with a programmed set point and steers an accumulator whose upper bits are the gain word. It can do this proportionally or by fixed signed steps.

Software programs the set point, two loop-rate sets (each with a separate rate for reducing and for raising the gain), gain limits, a double-buffered preload and the slot timing through a simple write port. A sync pulse restarts the slot position counter and can also transfer the preload. The slot position defines a window that can either switch the loop-rate set or limit adaptation to one part of the slot.

Top module: `agc_core`

## Requirements
- R1: The gain word holds the exponent e in bits [11:8] and the mantissa m in bits [7:0]. An accepted sample x (in_valid high at a rising edge) appears on out_i/out_q after that same edge as floor(x*(256+m)*2^e/256), with out_valid high for exactly that one cycle.
- R2: A scaled result outside the signed 16-bit range saturates to 32767 or -32768. The forward path never reduces the magnitude of a sample.
- R3: The estimator runs P passes, where P is 2 plus the value of control bits [7:5] (register 7), limited to 8. A sample accepted at edge E0 changes the gain word at edge E0+P+2 and at no earlier edge.
- R4: A scaled sample that arrives while the estimator is still busy is not measured and produces no gain update.
- R5: The error is the set point (register 0) minus the estimate. In proportional mode (control bit 2 = 0) the accumulator, which has 4 fraction bits below the gain word, gains floor(error*k/256).
- R6: In step mode (control bit 2 = 1) the accumulator moves by +k fraction units for a positive error, by -k for a negative error, and stays put for zero error.
- R7: k is the attack rate when the error is negative and the decay rate when it is positive. Set 0 uses registers 1 (attack) and 2 (decay); set 1 uses registers 3 and 4. Control bit 3 selects the set in continuous and sampled timing.
- R8: After an adaptive update the gain word lies between the lower limit (register 5) and the upper limit (register 6), inclusive.
- R9: A write to register 8 only fills the holding register. A write to register 9 copies the holding register into the gain word at that edge. A sync pulse does the same only when control bit 4 is set; otherwise it does not touch the gain.
- R10: The slot position restarts at 0 on sync and wraps after the value in register 10. The window covers positions p with delay <= p < delay+length (registers 11 and 12). In timed mode (control bits [1:0] = 1), set 0 applies inside the window and set 1 applies outside it.
- R11: In sampled mode (control bits [1:0] = 2) an update that falls outside the window leaves the gain unchanged.
- R12: After reset the gain word is 0, out_valid is low and out_i/out_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, at least 2 cycles apart |
| in_i | input | DATA_W | Input in-phase sample, signed |
| in_q | input | DATA_W | Input quadrature sample, signed |
| sync_in | input | 1 | Slot sync pulse |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | CFG_W | Register write data |
| out_valid | output | 1 | Scaled sample strobe |
| out_i | output | DATA_W | Scaled in-phase sample |
| out_q | output | DATA_W | Scaled quadrature sample |
| gain_word | output | EXP_W+MANT_W | Current forward gain word |

## Verification
The scaled pair is due one edge after the accepting edge, so it is sampled at the falling edge that follows. A gain update is due P+2 edges after the accepting edge: one edge to load the estimator, P passes, and one edge for the accumulator. The bench samples the gain both one edge before and at that edge. Slot-window cases place the sample a counted number of edges after the sync edge, so the position seen at the update edge is known exactly. Preload transfers are checked at the falling edge right after the write or sync edge.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    TM_CONT    = 2'd0,
    TM_TIMED   = 2'd1,
    TM_SAMPLED = 2'd2,
    TM_FREE    = 2'd3
  } tmode_e;

  localparam logic [3:0] A_THR  = 4'd0;
  localparam logic [3:0] A_ATT0 = 4'd1;
  localparam logic [3:0] A_DEC0 = 4'd2;
  localparam logic [3:0] A_ATT1 = 4'd3;
  localparam logic [3:0] A_DEC1 = 4'd4;
  localparam logic [3:0] A_LO   = 4'd5;
  localparam logic [3:0] A_HI   = 4'd6;
  localparam logic [3:0] A_CTRL = 4'd7;
  localparam logic [3:0] A_HOLD = 4'd8;
  localparam logic [3:0] A_XFER = 4'd9;
  localparam logic [3:0] A_SLOT = 4'd10;
  localparam logic [3:0] A_DLY  = 4'd11;
  localparam logic [3:0] A_LEN  = 4'd12;
endpackage

// File: rtl/agc_regs.sv
module agc_regs
  import agc_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int K_W    = 8,
  parameter int GAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  thr,
  output logic [K_W-1:0]    att0,
  output logic [K_W-1:0]    dec0,
  output logic [K_W-1:0]    att1,
  output logic [K_W-1:0]    dec1,
  output logic [GAIN_W-1:0] lim_lo,
  output logic [GAIN_W-1:0] lim_hi,
  output logic [GAIN_W-1:0] hold,
  output logic [CFG_W-1:0]  slot_last,
  output logic [CFG_W-1:0]  win_dly,
  output logic [CFG_W-1:0]  win_len,
  output tmode_e            tmode,
  output logic              median,
  output logic              cpu_set1,
  output logic              sync_ld,
  output logic [2:0]        pass_m2,
  output logic              xfer
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thr <= '0; att0 <= '0; dec0 <= '0; att1 <= '0; dec1 <= '0;
      lim_lo <= '0; lim_hi <= '1; hold <= '0;
      slot_last <= '1; win_dly <= '0; win_len <= '0;
      tmode <= TM_CONT; median <= 1'b0; cpu_set1 <= 1'b0;
      sync_ld <= 1'b0; pass_m2 <= '0;
    end else if (we) begin
      case (addr)
        A_THR:  thr       <= wdata;
        A_ATT0: att0      <= wdata[K_W-1:0];
        A_DEC0: dec0      <= wdata[K_W-1:0];
        A_ATT1: att1      <= wdata[K_W-1:0];
        A_DEC1: dec1      <= wdata[K_W-1:0];
        A_LO:   lim_lo    <= wdata[GAIN_W-1:0];
        A_HI:   lim_hi    <= wdata[GAIN_W-1:0];
        A_HOLD: hold      <= wdata[GAIN_W-1:0];
        A_SLOT: slot_last <= wdata;
        A_DLY:  win_dly   <= wdata;
        A_LEN:  win_len   <= wdata;
        A_CTRL: begin
          tmode    <= tmode_e'(wdata[1:0]);
          median   <= wdata[2];
          cpu_set1 <= wdata[3];
          sync_ld  <= wdata[4];
          pass_m2  <= wdata[7:5];
        end
        default: ;
      endcase
    end
  end

  // transfer strobe acts at the write edge itself
  assign xfer = we && (addr == A_XFER);
endmodule

// File: rtl/agc_fwd.sv
module agc_fwd #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 4,
  parameter int MANT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [EXP_W+MANT_W-1:0]  gain,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  localparam int PW = DATA_W + MANT_W + 2;
  localparam int SW = PW + (1 << EXP_W) - 1;

  logic [EXP_W-1:0]  g_exp;
  logic [MANT_W-1:0] g_man;
  assign g_exp = gain[EXP_W+MANT_W-1:MANT_W];
  assign g_man = gain[MANT_W-1:0];

  function automatic logic signed [DATA_W-1:0] scale(
    input logic signed [DATA_W-1:0] x,
    input logic [EXP_W-1:0]         e,
    input logic [MANT_W-1:0]        m);
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] sh;
    logic signed [SW-1:0] q;
    logic                 fits;
    prod = PW'(x) * PW'($signed({2'b01, m}));
    sh   = SW'(prod) <<< e;
    q    = sh >>> MANT_W;
    fits = (&q[SW-1:DATA_W-1]) || !(|q[SW-1:DATA_W-1]);
    if (fits) return q[DATA_W-1:0];
    return q[SW-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= scale(in_i, g_exp, g_man);
        out_q <= scale(in_q, g_exp, g_man);
      end
    end
  end
endmodule

// File: rtl/agc_mag.sv
module agc_mag #(
  parameter int DATA_W   = 16,
  parameter int MAX_PASS = 8,
  localparam int PC_W    = $clog2(MAX_PASS + 1),
  localparam int MAG_W   = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] s_i,
  input  logic signed [DATA_W-1:0] s_q,
  input  logic [PC_W-1:0]          passes,
  output logic                     busy,
  output logic                     done,
  output logic [MAG_W-1:0]         mag
);
  localparam int XW = DATA_W + 3;

  logic signed [XW-1:0] x_r, y_r, x_ld;
  logic [PC_W-1:0]      cnt;

  assign x_ld = s_i[DATA_W-1] ? -XW'(s_i) : XW'(s_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_r <= '0; y_r <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          x_r  <= x_ld;
          y_r  <= XW'(s_q);
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else begin
        // one vectoring rotation per clock, driving y toward zero
        if (!y_r[XW-1]) begin
          x_r <= x_r + (y_r >>> cnt);
          y_r <= y_r - (x_r >>> cnt);
        end else begin
          x_r <= x_r - (y_r >>> cnt);
          y_r <= y_r + (x_r >>> cnt);
        end
        cnt <= cnt + 1'b1;
        if (cnt == passes - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign mag = x_r[MAG_W-1:0];
endmodule

// File: rtl/agc_slot.sv
module agc_slot #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [CFG_W-1:0] slot_last,
  input  logic [CFG_W-1:0] win_dly,
  input  logic [CFG_W-1:0] win_len,
  output logic             in_win
);
  logic [CFG_W-1:0] pos;
  logic [CFG_W:0]   win_end;

  always_ff @(posedge clk) begin
    if (rst)                    pos <= '0;
    else if (sync)              pos <= '0;
    else if (pos >= slot_last)  pos <= '0;
    else                        pos <= pos + 1'b1;
  end

  assign win_end = {1'b0, win_dly} + {1'b0, win_len};
  assign in_win  = (pos >= win_dly) && ({1'b0, pos} < win_end);
endmodule

// File: rtl/agc_filter.sv
module agc_filter
  import agc_pkg::*;
#(
  parameter int GAIN_W = 12,
  parameter int FRAC_W = 4,
  parameter int K_W    = 8,
  parameter int K_SH   = 8,
  parameter int MAG_W  = 18,
  parameter int THR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mag_done,
  input  logic [MAG_W-1:0]  mag,
  input  logic [THR_W-1:0]  thr,
  input  logic [K_W-1:0]    att0,
  input  logic [K_W-1:0]    dec0,
  input  logic [K_W-1:0]    att1,
  input  logic [K_W-1:0]    dec1,
  input  logic [GAIN_W-1:0] lim_lo,
  input  logic [GAIN_W-1:0] lim_hi,
  input  logic [GAIN_W-1:0] hold,
  input  tmode_e            tmode,
  input  logic              median,
  input  logic              cpu_set1,
  input  logic              in_win,
  input  logic              load_evt,
  output logic              upd_en,
  output logic [GAIN_W-1:0] gain_word
);
  localparam int AW = GAIN_W + FRAC_W;
  localparam int EW = ((MAG_W > THR_W) ? MAG_W : THR_W) + 2;
  localparam int PW = EW + K_W + 1;
  localparam int SW = PW + 1;

  logic [AW-1:0]        acc, acc_nx;
  logic signed [EW-1:0] err;
  logic [K_W-1:0]       k;
  logic signed [PW-1:0] prod, delta;
  logic signed [SW-1:0] sum, lo_s, hi_s;
  logic                 use_set1, adapt_ok;

  always_comb begin
    err      = $signed(EW'(thr)) - $signed(EW'(mag));
    use_set1 = (tmode == TM_TIMED) ? !in_win : cpu_set1;
    adapt_ok = (tmode == TM_SAMPLED) ? in_win : 1'b1;
    if (err[EW-1]) k = use_set1 ? att1 : att0;
    else           k = use_set1 ? dec1 : dec0;
    prod = PW'(err) * $signed(PW'(k));
    if (median) begin
      if (err[EW-1])     delta = -$signed(PW'(k));
      else if (err == 0) delta = '0;
      else               delta = $signed(PW'(k));
    end else begin
      delta = prod >>> K_SH;
    end
    sum  = $signed(SW'(acc)) + SW'(delta);
    lo_s = $signed(SW'({lim_lo, {FRAC_W{1'b0}}}));
    hi_s = $signed(SW'({lim_hi, {FRAC_W{1'b0}}}));
    if (sum < lo_s)      acc_nx = {lim_lo, {FRAC_W{1'b0}}};
    else if (sum > hi_s) acc_nx = {lim_hi, {FRAC_W{1'b0}}};
    else                 acc_nx = sum[AW-1:0];
  end

  assign upd_en = mag_done && adapt_ok;

  always_ff @(posedge clk) begin
    if (rst)           acc <= '0;
    else if (load_evt) acc <= {hold, {FRAC_W{1'b0}}};
    else if (upd_en)   acc <= acc_nx;
  end

  assign gain_word = acc[AW-1:FRAC_W];
endmodule

// File: rtl/agc_core.sv
module agc_core
  import agc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int EXP_W    = 4,
  parameter int MANT_W   = 8,
  parameter int FRAC_W   = 4,
  parameter int K_W      = 8,
  parameter int K_SH     = 8,
  parameter int CFG_W    = 16,
  parameter int MAX_PASS = 8,
  localparam int GAIN_W  = EXP_W + MANT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic                     sync_in,
  input  logic                     cfg_we,
  input  logic [3:0]               cfg_addr,
  input  logic [CFG_W-1:0]         cfg_wdata,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic [GAIN_W-1:0]        gain_word
);
  localparam int MAG_W = DATA_W + 2;
  localparam int PC_W  = $clog2(MAX_PASS + 1);

  logic [CFG_W-1:0]  thr, slot_last, win_dly, win_len;
  logic [K_W-1:0]    att0, dec0, att1, dec1;
  logic [GAIN_W-1:0] lim_lo, lim_hi, hold;
  tmode_e            tmode;
  logic              median, cpu_set1, sync_ld, xfer;
  logic [2:0]        pass_m2;
  logic [PC_W:0]     pass_raw;
  logic [PC_W-1:0]   pass_n;
  logic              mag_busy, mag_done, in_win, load_evt, upd_en;
  logic [MAG_W-1:0]  mag;

  agc_regs #(.CFG_W(CFG_W), .K_W(K_W), .GAIN_W(GAIN_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .thr(thr), .att0(att0), .dec0(dec0), .att1(att1), .dec1(dec1),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .hold(hold),
    .slot_last(slot_last), .win_dly(win_dly), .win_len(win_len),
    .tmode(tmode), .median(median), .cpu_set1(cpu_set1),
    .sync_ld(sync_ld), .pass_m2(pass_m2), .xfer(xfer));

  assign pass_raw = (PC_W+1)'(pass_m2) + (PC_W+1)'(2);
  assign pass_n   = (pass_raw > (PC_W+1)'(MAX_PASS)) ? PC_W'(MAX_PASS) : pass_raw[PC_W-1:0];
  assign load_evt = xfer || (sync_in && sync_ld);

  agc_fwd #(.DATA_W(DATA_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_fwd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .gain(gain_word), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  agc_mag #(.DATA_W(DATA_W), .MAX_PASS(MAX_PASS)) u_mag (
    .clk(clk), .rst(rst), .start(out_valid), .s_i(out_i), .s_q(out_q),
    .passes(pass_n), .busy(mag_busy), .done(mag_done), .mag(mag));

  agc_slot #(.CFG_W(CFG_W)) u_slot (
    .clk(clk), .rst(rst), .sync(sync_in), .slot_last(slot_last),
    .win_dly(win_dly), .win_len(win_len), .in_win(in_win));

  agc_filter #(.GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .K_W(K_W), .K_SH(K_SH),
               .MAG_W(MAG_W), .THR_W(CFG_W)) u_filt (
    .clk(clk), .rst(rst), .mag_done(mag_done), .mag(mag), .thr(thr),
    .att0(att0), .dec0(dec0), .att1(att1), .dec1(dec1),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .hold(hold), .tmode(tmode),
    .median(median), .cpu_set1(cpu_set1), .in_win(in_win),
    .load_evt(load_evt), .upd_en(upd_en), .gain_word(gain_word));
endmodule

// File: rtl/agc_core_chk.sv
module agc_core_chk #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic [GAIN_W-1:0]        gain_word,
  input logic                     mag_done,
  input logic                     load_evt,
  input logic                     upd_en,
  input logic [GAIN_W-1:0]        lim_lo,
  input logic [GAIN_W-1:0]        lim_hi
);
  function automatic logic [DATA_W:0] absv(input logic signed [DATA_W-1:0] v);
    logic signed [DATA_W:0] w;
    w = {v[DATA_W-1], v};
    return w[DATA_W] ? DATA_W'(0) - w : w;
  endfunction

  // R1: one-cycle strobe latency
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2: the forward path only adds gain
  assert_no_shrink_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (absv(out_i) >= absv($past(in_i))) && (absv(out_q) >= absv($past(in_q))));

  // R3: the estimator reports one single-cycle result per measurement
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mag_done |=> !mag_done);

  // R9 / R11: the gain moves only after a measurement or a preload
  assert_gain_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!mag_done && !load_evt) |=> $stable(gain_word));

  // R8: adaptive updates land inside the limits
  assert_in_limits_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !load_evt) |=> (gain_word >= $past(lim_lo)) && (gain_word <= $past(lim_hi)));
endmodule

bind agc_core agc_core_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .gain_word(gain_word),
  .mag_done(mag_done), .load_evt(load_evt), .upd_en(upd_en),
  .lim_lo(lim_lo), .lim_hi(lim_hi));

// File: tb/tb_agc_core.sv
module tb_agc_core;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic               sync_in = 1'b0;
  logic               cfg_we = 1'b0;
  logic [3:0]         cfg_addr = '0;
  logic [15:0]        cfg_wdata = '0;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;
  logic [11:0]        gain_word;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  agc_core dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .sync_in(sync_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .gain_word(gain_word));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint fwd(input longint x, input int g);
    longint p;
    p = x * (256 + (g & 255));
    p = p * (longint'(1) << ((g >> 8) & 15));
    p = p >>> 8;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  function automatic logic [15:0] ctl(input int tm, input bit med, input bit s1,
                                      input bit sld, input int np);
    return 16'((((np - 2) & 7) << 5) | (int'(sld) << 4) | (int'(s1) << 3) |
               (int'(med) << 2) | (tm & 3));
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic preload(input int g);
    wr(8, g); wr(9, 0);
  endtask

  task automatic send(input int i, input int q);
    @(negedge clk); in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  // after send: wait until the update edge E0+np+2 and sample after it
  task automatic wait_upd(input int np);
    repeat (np + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_loop(input int thr, input int a0, input int d0,
                          input int a1, input int d1, input int lo, input int hi);
    wr(0, thr); wr(1, a0); wr(2, d0); wr(3, a1); wr(4, d1); wr(5, lo); wr(6, hi);
  endtask

  task automatic t_reset();
    chk("R12 gain after reset", gain_word, 0);
    chk("R12 out_valid after reset", out_valid, 0);
    chk("R12 out_i after reset", out_i, 0);
    chk("R12 out_q after reset", out_q, 0);
  endtask

  task automatic fwd_case(input int g, input int i, input int q, input string tag);
    wr(5, g); wr(6, g); preload(g);
    send(i, q);
    chk({tag, " out_valid"}, out_valid, 1);
    chk({tag, " I"}, out_i, fwd(i, g));
    chk({tag, " Q"}, out_q, fwd(q, g));
    @(negedge clk);
    chk("R1 strobe one cycle", out_valid, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_forward();
    wr(7, ctl(0, 0, 0, 0, 2));
    fwd_case(12'h000, 1234, -567, "R1 unity");
    fwd_case(12'h280, 1000, -2000, "R1 x6");
    fwd_case(12'h2C0, 3, -3, "R1 x7 rounding");
    fwd_case(12'h280, 10000, -10000, "R2 saturate");
    fwd_case(12'hF00, 1, -1, "R2 top exponent");
    wr(5, 0); wr(6, 12'hFFF);
  endtask

  task automatic t_mean();
    set_loop(4096, 0, 64, 0, 0, 0, 12'hFFF);
    wr(7, ctl(0, 0, 0, 0, 2));
    preload(12'h100);
    send(0, 0);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R3 no early update", gain_word, 12'h100);
    @(posedge clk); @(negedge clk);
    chk("R5 proportional step", gain_word, 12'h140);
    wr(6, 12'h160);
    send(0, 0); wait_upd(2);
    chk("R8 upper clamp", gain_word, 12'h160);
  endtask

  task automatic t_median();
    set_loop(4096, 32, 48, 80, 16, 0, 12'hFFF);
    wr(7, ctl(0, 1, 0, 0, 2));
    preload(12'h100);
    send(20000, 0); wait_upd(2);
    chk("R6 R7 set0 attack", gain_word, 12'h0FE);
    send(10, 0); wait_upd(2);
    chk("R6 R7 set0 decay", gain_word, 12'h101);
    wr(7, ctl(0, 1, 1, 0, 2));
    send(20000, 0); wait_upd(2);
    chk("R7 set1 attack", gain_word, 12'h0FC);
    send(10, 0); wait_upd(2);
    chk("R7 set1 decay", gain_word, 12'h0FD);
    wr(7, ctl(0, 1, 0, 0, 2));
    wr(5, 12'h0FF); preload(12'h100);
    send(20000, 0); wait_upd(2);
    chk("R8 lower clamp", gain_word, 12'h0FF);
    wr(5, 0);
  endtask

  task automatic t_passes();
    wr(7, ctl(0, 1, 0, 0, 8));
    preload(12'h100);
    send(20000, 0);
    repeat (9) @(posedge clk); @(negedge clk);
    chk("R3 eight passes not yet", gain_word, 12'h100);
    @(posedge clk); @(negedge clk);
    chk("R3 eight passes due", gain_word, 12'h0FE);
    preload(12'h100);
    send(10, 0); send(10, 0);
    repeat (20) @(negedge clk);
    chk("R4 busy sample ignored", gain_word, 12'h103);
  endtask

  task automatic t_preload();
    wr(7, ctl(0, 0, 0, 0, 2));
    preload(12'h0C0);
    wr(8, 12'h050);
    chk("R9 hold write alone", gain_word, 12'h0C0);
    wr(9, 0);
    chk("R9 strobe transfer", gain_word, 12'h050);
    wr(8, 12'h0A0);
    pulse_sync();
    chk("R9 sync ignored when disabled", gain_word, 12'h050);
    wr(7, ctl(0, 0, 0, 1, 2));
    pulse_sync();
    chk("R9 sync transfer", gain_word, 12'h0A0);
  endtask

  // sample placed k falling edges after the sync; update sees position k+5
  task automatic slot_shot(input int k);
    pulse_sync();
    repeat (k) @(negedge clk);
    send(20000, 0); wait_upd(2);
  endtask

  task automatic t_slots();
    set_loop(4096, 32, 48, 80, 16, 0, 12'hFFF);
    wr(10, 999); wr(11, 20); wr(12, 20);
    wr(7, ctl(2, 1, 0, 0, 2));
    preload(12'h100);
    slot_shot(0);
    chk("R11 held outside window", gain_word, 12'h100);
    slot_shot(20);
    chk("R11 adapts inside window", gain_word, 12'h0FE);
    wr(7, ctl(1, 1, 0, 0, 2));
    preload(12'h100);
    slot_shot(0);
    chk("R10 timed outside uses set1", gain_word, 12'h0FB);
    slot_shot(20);
    chk("R10 timed inside uses set0", gain_word, 12'h0F9);
    wr(10, 9); wr(11, 2); wr(12, 3);
    wr(7, ctl(2, 1, 0, 0, 2));
    preload(12'h100);
    slot_shot(8);
    chk("R10 position wraps", gain_word, 12'h0FE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_forward();
    t_mean();
    t_median();
    t_passes();
    t_preload();
    t_slots();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule